// File: doc/BRIEF.md
# SMBus Backlight Register Interface

This block is the serial control port of an LED backlight controller. It is a slave on a two-wire SMBus, answering to a fixed 7-bit address, and holds four byte-wide registers: a brightness level, a control byte that sets the dimming mode and switches the backlight on or off, a read-only status byte built from fault flags supplied by the rest of the chip, and a read-only identification byte. The host uses the SMBus write-byte and read-byte protocols to reach them.

SCL and SDA are sampled by the system clock through a synchronizer. Start and stop conditions and SCL edges are found in the sampled stream. A byte engine shifts bits in and out, pulls SDA low for acknowledges and for zero bits of returned data, and changes SDA only after a falling SCL edge. The register file decodes the dimming mode, applies the brightness write rule and times the backlight enable with a cycle counter.

Top module: `smb_backlight_regs`

## Requirements
- R1: The slave answers only to the 7-bit address 0x2C, which is the byte 0x58 with R/W=0 (write) or 0x59 with R/W=1 (read). Any other address byte gets no acknowledge, and the rest of that transfer, up to the next start, changes no register.
- R2: A write byte is a start, the address with R/W=0, a command byte that picks the register, a data byte and a stop. The slave pulls SDA low during the ninth clock of each of these three bytes.
- R3: A read byte is a start, the address for write, the command, a repeated start, the address with R/W=1, and then one data byte that the slave shifts out MSB first. The slave acknowledges the three bytes it receives and changes SDA only after a falling SCL edge.
- R4: Command 0x00 is the brightness level, with a reset value of 0xFF, and a read always returns the stored value. A write is stored only while control bit 1 is 0. While that bit is 1 the write is acknowledged and then discarded.
- R5: Command 0x01 is the control byte, with a reset value of 0x00. Bit 0 switches the backlight, bit 1 selects PWM dimming and bit 2 picks absolute (1) or percent (0) scaling. Bits 7:3 read as 0, and values written to them are dropped.
- R6: mode_o is 2'b10 (PWM) whenever control bit 1 is 1, whatever bit 2 holds. With bit 1 at 0 it is 2'b00 (SMBus absolute) when bit 2 is 1 and 2'b01 (SMBus percent) when bit 2 is 0.
- R7: bl_en_o goes to 1 exactly ON_DELAY clock cycles after control bit 0 is stored as 1. It drops in the same cycle that the bit is stored as 0.
- R8: Command 0x02 is the status byte, read-only and 0x00 after reset. Bit 1 is the thermal fault, bit 4 means one or more strings are disabled, bit 5 means two or more are, bit 0 is the OR of the thermal fault and bit 4, and bit 3 follows bl_en_o. All other bits are 0, and writes to this command are dropped.
- R9: Command 0x03 is the identification byte, read-only, and reads 0xB0. Bit 7 is the panel-type flag (1), bits 6:3 hold the manufacturer field (6) and bits 2:0 hold the revision (0). Writes to it are dropped.
- R10: A command above 0x03 is acknowledged, reads as 0x00, and a write to it changes no register.
- R11: bright_o always shows the stored brightness level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| therm_fault_i | input | 1 | Thermal shutdown flag |
| str_off_i | input | NSTR | One flag per LED string that is disabled by a fault |
| bright_o | output | 8 | Stored brightness level |
| mode_o | output | 2 | Dimming mode: 00 SMBus absolute, 01 SMBus percent, 10 PWM |
| bl_en_o | output | 1 | Backlight enable |

## Verification
The hardest case to reach is the bus turnaround in a read. The slave must keep the command from the first half of the read, accept a repeated start in the middle of the transfer, and then take over SDA for the returned byte. The bench drives complete read-byte sequences with the repeated start for every register and for a command beyond the map. Those reads also show the two writes that are dropped: a brightness write made while PWM dimming is selected, and writes to the status, identification and unmapped commands. The bench also times the backlight enable across its delay window and ramps the fault inputs through the one-string and two-string counts.

// File: rtl/smbr_pkg.sv
package smbr_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_BRT = 8'h00;
  localparam logic [BYTE_W-1:0] CMD_CTL = 8'h01;
  localparam logic [BYTE_W-1:0] CMD_STS = 8'h02;
  localparam logic [BYTE_W-1:0] CMD_ID  = 8'h03;

  typedef enum logic [1:0] {
    MODE_SMB_ABS = 2'b00,
    MODE_SMB_PCT = 2'b01,
    MODE_PWM     = 2'b10
  } dim_mode_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ACK_A, ST_CMD, ST_ACK_C,
    ST_WDAT, ST_ACK_W, ST_RDAT, ST_RACK, ST_HOLD
  } eng_state_e;

  // PWM select overrides the scaling bit.
  function automatic dim_mode_e decode_mode(input logic pwm_sel, input logic pwm_abs);
    if (pwm_sel)      return MODE_PWM;
    else if (pwm_abs) return MODE_SMB_ABS;
    else              return MODE_SMB_PCT;
  endfunction

  function automatic logic [BYTE_W-1:0] status_pack(input logic therm, input logic bl_on,
                                                    input logic one_off, input logic two_off);
    return {2'b00, two_off, one_off, bl_on, 1'b0, therm, therm | one_off};
  endfunction

  function automatic logic [BYTE_W-1:0] id_pack(input logic panel, input logic [3:0] mfg,
                                                input logic [2:0] rev);
    return {panel, mfg, rev};
  endfunction

endpackage

// File: rtl/smbr_sync.sv
module smbr_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop,
  output logic sda_lvl
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] scl_sh, sda_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[SH_W-2:0], scl_i};
      sda_sh <= {sda_sh[SH_W-2:0], sda_i};
    end
  end

  logic scl_now, scl_prev, sda_now, sda_prev;
  assign scl_now  = scl_sh[SYNC_STAGES-1];
  assign scl_prev = scl_sh[SYNC_STAGES];
  assign sda_now  = sda_sh[SYNC_STAGES-1];
  assign sda_prev = sda_sh[SYNC_STAGES];

  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  assign bus_start = scl_now & scl_prev & sda_prev & ~sda_now;
  assign bus_stop  = scl_now & scl_prev & ~sda_prev & sda_now;
  assign sda_lvl   = sda_now;
endmodule

// File: rtl/smbr_engine.sv
module smbr_engine
  import smbr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              sda_lvl,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] reg_idx,
  output logic [BYTE_W-1:0] wr_data,
  output eng_state_e        state
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  logic [BYTE_W-1:0] shreg, txreg, cmd_q;
  logic [CNT_W-1:0]  bitcnt;
  logic              rw_q;

  assign reg_idx = cmd_q;
  assign wr_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      shreg  <= '0;
      txreg  <= '0;
      cmd_q  <= '0;
      bitcnt <= '0;
      rw_q   <= 1'b0;
      sda_oe <= 1'b0;
      wr_stb <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (bus_stop) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (bus_start) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_CMD, ST_WDAT: begin
            if (scl_rise) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == FULL) begin
              bitcnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                  rw_q   <= shreg[0];
                  sda_oe <= 1'b1;
                  state  <= ST_ACK_A;
                end else begin
                  state  <= ST_HOLD;
                end
              end else if (state == ST_CMD) begin
                cmd_q  <= shreg;
                sda_oe <= 1'b1;
                state  <= ST_ACK_C;
              end else begin
                wr_stb <= 1'b1;
                sda_oe <= 1'b1;
                state  <= ST_ACK_W;
              end
            end
          end
          ST_ACK_A: if (scl_fall) begin
            if (rw_q) begin
              txreg  <= rd_data;
              sda_oe <= ~rd_data[BYTE_W-1];
              bitcnt <= '0;
              state  <= ST_RDAT;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_CMD;
            end
          end
          ST_ACK_C: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_WDAT;
          end
          ST_ACK_W: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_HOLD;
          end
          ST_RDAT: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == FULL) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~txreg[BYTE_W-2];
              end
            end
          end
          ST_RACK: if (scl_fall) state <= ST_HOLD;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smbr_regs.sv
module smbr_regs
  import smbr_pkg::*;
#(
  parameter int          NSTR     = 8,
  parameter int          ON_DELAY = 500000,
  parameter logic [3:0]  ID_MFG   = 4'd6,
  parameter logic [2:0]  ID_REV   = 3'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] reg_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              therm_fault,
  input  logic [NSTR-1:0]   str_off,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] bright,
  output logic              ctl_bl,
  output dim_mode_e         mode,
  output logic              bl_en,
  output logic [BYTE_W-1:0] sts_byte
);
  localparam int CW    = $clog2(NSTR + 1);
  localparam int DLY_W = $clog2(ON_DELAY + 1);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(ON_DELAY - 1);

  logic [2:0]       ctl_q;
  logic [DLY_W-1:0] dly_q;
  logic             en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bright <= '1;
      ctl_q  <= '0;
    end else if (wr_stb) begin
      if (reg_idx == CMD_BRT && !ctl_q[1]) bright <= wr_data;
      if (reg_idx == CMD_CTL)              ctl_q  <= wr_data[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      en_q  <= 1'b0;
    end else if (!ctl_q[0]) begin
      dly_q <= '0;
      en_q  <= 1'b0;
    end else if (!en_q) begin
      if (dly_q == DLY_LAST) en_q  <= 1'b1;
      else                   dly_q <= dly_q + 1'b1;
    end
  end

  assign ctl_bl = ctl_q[0];
  assign bl_en  = en_q & ctl_q[0];
  assign mode   = decode_mode(ctl_q[1], ctl_q[2]);

  logic [CW-1:0] n_off;
  always_comb begin
    n_off = '0;
    for (int i = 0; i < NSTR; i++) n_off = n_off + CW'(str_off[i]);
  end

  assign sts_byte = status_pack(therm_fault, bl_en, n_off != '0, n_off > CW'(1));

  always_comb begin
    case (reg_idx)
      CMD_BRT: rd_data = bright;
      CMD_CTL: rd_data = {5'b0, ctl_q};
      CMD_STS: rd_data = sts_byte;
      CMD_ID:  rd_data = id_pack(1'b1, ID_MFG, ID_REV);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/smb_backlight_regs.sv
module smb_backlight_regs
  import smbr_pkg::*;
#(
  parameter int         NSTR     = 8,
  parameter int         ON_DELAY = 500000,
  parameter logic [6:0] DEV_ADDR = 7'h2C
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe_o,
  input  logic            therm_fault_i,
  input  logic [NSTR-1:0] str_off_i,
  output logic [7:0]      bright_o,
  output logic [1:0]      mode_o,
  output logic            bl_en_o
);
  logic scl_rise_w, scl_fall_w, start_w, stop_w, sda_lvl_w;
  logic wr_stb_w, ctl_bl_w, drive_ok_w;
  logic [BYTE_W-1:0] idx_w, wdat_w, rdat_w, sts_w;
  eng_state_e state_w;
  dim_mode_e  mode_w;

  smbr_sync #(.SYNC_STAGES(2)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise_w), .scl_fall(scl_fall_w),
    .bus_start(start_w), .bus_stop(stop_w), .sda_lvl(sda_lvl_w)
  );

  smbr_engine #(.DEV_ADDR(DEV_ADDR)) eng_i (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise_w), .scl_fall(scl_fall_w),
    .bus_start(start_w), .bus_stop(stop_w), .sda_lvl(sda_lvl_w),
    .rd_data(rdat_w), .sda_oe(sda_oe_o), .wr_stb(wr_stb_w),
    .reg_idx(idx_w), .wr_data(wdat_w), .state(state_w)
  );

  smbr_regs #(.NSTR(NSTR), .ON_DELAY(ON_DELAY)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb_w), .reg_idx(idx_w),
    .wr_data(wdat_w), .therm_fault(therm_fault_i), .str_off(str_off_i),
    .rd_data(rdat_w), .bright(bright_o), .ctl_bl(ctl_bl_w),
    .mode(mode_w), .bl_en(bl_en_o), .sts_byte(sts_w)
  );

  assign mode_o = mode_w;

  // States in which the slave may own SDA.
  assign drive_ok_w = (state_w == ST_ACK_A) || (state_w == ST_ACK_C) ||
                      (state_w == ST_ACK_W) || (state_w == ST_RDAT);
endmodule

// File: rtl/smbr_chk.sv
module smbr_chk
  import smbr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       scl_fall,
  input logic       drive_ok,
  input logic [1:0] mode,
  input logic [7:0] bright,
  input logic       ctl_bl,
  input logic       bl_en,
  input logic [7:0] sts
);
  assert_oe_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  assert_drive_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> drive_ok);

  assert_bright_hold_pwm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PWM) |=> $stable(bright));

  assert_bl_off_now_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_bl |-> !bl_en);

  assert_bl_on_after_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bl_en) |-> $past(ctl_bl));

  assert_two_implies_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sts[5] |-> (sts[4] && sts[0]));

  assert_status_bl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sts[3] == bl_en);

  assert_mode_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);
endmodule

bind smb_backlight_regs smbr_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .scl_fall(scl_fall_w),
  .drive_ok(drive_ok_w), .mode(mode_o), .bright(bright_o),
  .ctl_bl(ctl_bl_w), .bl_en(bl_en_o), .sts(sts_w)
);

// File: tb/smb_backlight_regs_tb.sv
module smb_backlight_regs_tb_top;
  localparam int NSTR = 8;
  localparam int DLY  = 300;
  localparam int H    = 8;
  localparam int NV   = 21;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1;

  // {op, cmd, data, expected read}
  localparam logic [25:0] VEC [NV] = '{
    {OP_RD, 8'h00, 8'h00, 8'hFF},  // R4 reset level
    {OP_RD, 8'h01, 8'h00, 8'h00},  // R5 reset control
    {OP_RD, 8'h02, 8'h00, 8'h00},  // R8 reset status
    {OP_RD, 8'h03, 8'h00, 8'hB0},  // R9 id
    {OP_WR, 8'h00, 8'h3C, 8'h00},
    {OP_RD, 8'h00, 8'h00, 8'h3C},  // R4 stored
    {OP_WR, 8'h01, 8'hFA, 8'h00},  // R5 reserved bits dropped
    {OP_RD, 8'h01, 8'h00, 8'h02},
    {OP_WR, 8'h00, 8'h11, 8'h00},  // R4 ignored in PWM mode
    {OP_RD, 8'h00, 8'h00, 8'h3C},
    {OP_WR, 8'h03, 8'h00, 8'h00},
    {OP_RD, 8'h03, 8'h00, 8'hB0},  // R9 read-only
    {OP_WR, 8'h02, 8'hFF, 8'h00},
    {OP_RD, 8'h02, 8'h00, 8'h00},  // R8 read-only
    {OP_WR, 8'h07, 8'h55, 8'h00},
    {OP_RD, 8'h07, 8'h00, 8'h00},  // R10 unmapped
    {OP_WR, 8'h01, 8'h04, 8'h00},
    {OP_WR, 8'h00, 8'hA5, 8'h00},
    {OP_RD, 8'h00, 8'h00, 8'hA5},
    {OP_RD, 8'h01, 8'h00, 8'h04},
    {OP_RD, 8'hFF, 8'h00, 8'h00}   // R10 top command
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_d = 1'b1, sda_d = 1'b1;
  logic therm = 1'b0;
  logic [NSTR-1:0] str_off = '0;
  logic sda_oe, bl_en;
  logic [7:0] bright;
  logic [1:0] mode;
  wire sda_bus = sda_d & ~sda_oe;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  smb_backlight_regs #(.NSTR(NSTR), .ON_DELAY(DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_d), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .therm_fault_i(therm), .str_off_i(str_off), .bright_o(bright),
    .mode_o(mode), .bl_en_o(bl_en)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [7:0] cmd);
    case (cmd)
      8'h00:   return "R4";
      8'h01:   return "R5";
      8'h02:   return "R8";
      8'h03:   return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic bus_start();
    sda_d = 1'b1; tick(H); scl_d = 1'b1; tick(H);
    sda_d = 1'b0; tick(H); scl_d = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    sda_d = 1'b0; tick(H); scl_d = 1'b1; tick(H);
    sda_d = 1'b1; tick(H);
  endtask

  task automatic send_bit(input logic b);
    sda_d = b; tick(H); scl_d = 1'b1; tick(H); scl_d = 1'b0; tick(2);
  endtask

  task automatic recv_bit(output logic b);
    sda_d = 1'b1; tick(H); scl_d = 1'b1; tick(H/2);
    b = sda_bus; tick(H/2); scl_d = 1'b0; tick(2);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(1'b1);
  endtask

  task automatic smb_write(input logic [7:0] cmd, input logic [7:0] dat, output logic ok);
    logic a0, a1, a2;
    bus_start();
    send_byte(8'h58, a0);
    send_byte(cmd, a1);
    send_byte(dat, a2);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic smb_read(input logic [7:0] cmd, output logic [7:0] dat, output logic ok);
    logic a0, a1, a2;
    bus_start();
    send_byte(8'h58, a0);
    send_byte(cmd, a1);
    bus_start();
    send_byte(8'h59, a2);
    recv_byte(dat);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ok, ack;
    logic [7:0] rd;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // reset state at the ports
    check("R11 reset bright_o", bright, 8'hFF);
    check("R6 reset mode_o", {6'b0, mode}, 8'h01);
    check("R7 reset bl_en_o", {7'b0, bl_en}, 8'h00);
    check("R3 idle sda_oe_o", {7'b0, sda_oe}, 8'h00);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][25:24] == OP_WR) begin
        smb_write(VEC[v][23:16], VEC[v][15:8], ok);
        check("R2 write acks", {7'b0, ok}, 8'h01);
      end else begin
        smb_read(VEC[v][23:16], rd, ok);
        check("R3 read acks", {7'b0, ok}, 8'h01);
        check(tag_of(VEC[v][23:16]), rd, VEC[v][7:0]);
      end
    end

    check("R11 bright_o follows level", bright, 8'hA5);
    check("R6 absolute mode", {6'b0, mode}, 8'h00);
    smb_write(8'h01, 8'h06, ok);
    check("R6 PWM overrides scaling bit", {6'b0, mode}, 8'h02);
    smb_write(8'h01, 8'h02, ok);
    check("R6 PWM with bit2 clear", {6'b0, mode}, 8'h02);
    smb_write(8'h01, 8'h00, ok);
    check("R6 percent mode", {6'b0, mode}, 8'h01);

    // R1: foreign address is not acknowledged and changes nothing
    bus_start();
    send_byte(8'h5A, ack);
    check("R1 foreign address NACK", {7'b0, ack}, 8'h00);
    send_byte(8'h00, ack);
    send_byte(8'h77, ack);
    bus_stop();
    smb_read(8'h00, rd, ok);
    check("R1 level kept after foreign write", rd, 8'hA5);
    bus_start();
    send_byte(8'h59, ack);
    check("R1 read address ACK", {7'b0, ack}, 8'h01);
    recv_byte(rd);
    bus_stop();

    // R7: enable delay and immediate off
    smb_write(8'h01, 8'h01, ok);
    check("R7 still off inside window", {7'b0, bl_en}, 8'h00);
    tick(DLY);
    check("R7 on after window", {7'b0, bl_en}, 8'h01);
    smb_read(8'h02, rd, ok);
    check("R8 status backlight bit", rd, 8'h08);
    smb_write(8'h01, 8'h00, ok);
    check("R7 off at once", {7'b0, bl_en}, 8'h00);

    // R8: fault flags
    therm = 1'b1;
    smb_read(8'h02, rd, ok);
    check("R8 thermal", rd, 8'h03);
    therm = 1'b0; str_off = 8'h04;
    smb_read(8'h02, rd, ok);
    check("R8 one string", rd, 8'h11);
    str_off = 8'h81;
    smb_read(8'h02, rd, ok);
    check("R8 two strings", rd, 8'h31);
    therm = 1'b1;
    smb_read(8'h02, rd, ok);
    check("R8 thermal and two strings", rd, 8'h33);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule